// File: doc/BRIEF.md
# Sub-word Memory Access Aligner

This block connects a load/store unit to a memory that is organised in 8-byte rows. A request carries a byte address, a size of 1, 2, 4 or 8 bytes, a byte-reversal enable, store data and a load/store select. The block turns the byte address into a row index and presents it to the row memory. On a load it shifts the addressed byte lanes of the returned row down to bit 0, masks off the other lanes and can reverse the byte order of the result. On a store it reverses the store data's bytes if asked, places them into the addressed lane of the current row and writes the full row back in the request cycle. This read-modify-write needs no extra cycle.

The row memory port reads combinationally: `mem_addr` selects a row and `mem_rdata` returns it in the same cycle. A write happens at the clock edge that ends the request cycle while `mem_we` is high. Every request gives one response on the following cycle. A request whose offset is not a multiple of its size is rejected with an error response and does not reach the memory.

Top module: `subword_aligner`

## Requirements
- R1: `mem_addr` equals the request byte address shifted right by 3, in the same cycle as the request. Byte lane k of a row is bits [8k+7:8k], and byte offset 0 within a row is the least significant byte.
- R2: A legal load whose size code is s (size 2^s bytes) at byte offset o returns row bytes o to o+2^s-1 in the low bytes of `rsp_rdata`, with all higher bits zero. The data appears with `rsp_valid` one cycle after the request.
- R3: A request is misaligned when (o AND (2^s − 1)) is not zero. A misaligned request raises `rsp_err` for exactly its response cycle, returns zero data and leaves `mem_we` low.
- R4: A legal narrow store drives `mem_we` high in the request cycle. The `mem_wdata` it drives is the current row with lanes o to o+2^s-1 replaced by the low 2^s bytes of the store data, and every other byte unchanged.
- R5: Bits of `req_wdata` above the access size have no effect on the stored row.
- R6: When `req_swap` is set on a load, the byte order of the extracted 2^s-byte value is reversed before it is returned.
- R7: When `req_swap` is set on a store, the low 2^s bytes of the store data are reversed before they are merged into the row.
- R8: An 8-byte access at offset 0 returns or writes the whole row. The stored row does not depend on the row's previous contents.
- R9: `rsp_valid` is high exactly one cycle after each request and low otherwise. Store responses carry zero data and, when aligned, no error.
- R10: After reset, `rsp_valid` and `rsp_err` are low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access size in bytes (0 = 1 byte, 3 = 8 bytes) |
| req_swap | input | 1 | Reverse byte order of the access |
| req_wdata | input | 64 | Store data, right-justified |
| mem_addr | output | ADDR_W-3 | Row index |
| mem_rdata | input | 64 | Row contents, combinational read |
| mem_we | output | 1 | Row write enable |
| mem_wdata | output | 64 | Merged row to write |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Load result, right-justified |
| rsp_err | output | 1 | Alignment error |

## Verification
The bench targets the edge lanes of a row, such as byte 7 and a halfword at offset 6. A design with a wrong lane shift or mask width returns bytes from a neighbouring lane there. It also stores with junk in the upper data bits and then reads the row back, which exposes a store merge that forgets to mask the source. Swapped loads and stores of every size are compared with byte-reversed expectations, so a design that reverses all eight bytes instead of only the accessed ones gets shifted data. Misaligned stores are followed by loads of the same row, so a design that still writes on an error shows a corrupted row.

// File: rtl/subword_aligner.sv
module subword_aligner #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_swap,
  input  logic [63:0]       req_wdata,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              mem_we,
  output logic [63:0]       mem_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int OFF_W = 3;

  logic [OFF_W-1:0] off;
  logic [3:0]       nbytes;
  logic             misalign;
  logic [5:0]       shamt;
  logic [63:0]      lane_mask, ld_raw, ld_data, st_src;

  function automatic logic [63:0] rev_bytes(input logic [63:0] d, input logic [1:0] sz);
    logic [63:0] r;
    case (sz)
      2'd0:    r = {56'd0, d[7:0]};
      2'd1:    r = {48'd0, d[7:0], d[15:8]};
      2'd2:    r = {32'd0, d[7:0], d[15:8], d[23:16], d[31:24]};
      default: r = {<<8{d}};
    endcase
    return r;
  endfunction

  assign off       = req_addr[OFF_W-1:0];
  assign nbytes    = 4'd1 << req_size;
  assign misalign  = |(off & (nbytes[2:0] - 3'd1));
  assign shamt     = {off, 3'b000};
  assign lane_mask = (req_size == 2'd3) ? '1 : ((64'd1 << {nbytes, 3'b000}) - 64'd1);

  assign ld_raw  = (mem_rdata >> shamt) & lane_mask;
  assign ld_data = req_swap ? rev_bytes(ld_raw, req_size) : ld_raw;
  assign st_src  = req_swap ? rev_bytes(req_wdata, req_size) : (req_wdata & lane_mask);

  assign mem_addr  = req_addr[ADDR_W-1:OFF_W];
  assign mem_we    = req_valid & req_store & ~misalign;
  assign mem_wdata = (mem_rdata & ~(lane_mask << shamt)) | (st_src << shamt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & misalign;
      rsp_rdata <= (req_valid & ~req_store & ~misalign) ? ld_data : '0;
    end
  end

  AST_ROW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> mem_addr == req_addr[ADDR_W-1:OFF_W]); // R1
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[0] && req_size != 2'd0) |-> !mem_we); // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'd0)); // R3
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |-> !mem_we); // R2
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err)); // R9
  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> rsp_rdata == 64'd0); // R9
endmodule

// File: tb/subword_aligner_bench.sv
module subword_aligner_bench;
  localparam int AW = 8;
  localparam int ROWS = 1 << (AW - 3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_swap = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [AW-4:0] mem_addr;
  logic [63:0] mem_rdata, mem_wdata, rsp_rdata;
  logic mem_we, rsp_valid, rsp_err;

  logic [63:0] bmem [ROWS] = '{default: 64'd0};
  logic [63:0] ref_mem [ROWS] = '{default: 64'd0};

  typedef struct { logic [63:0] d; logic e; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  subword_aligner #(.ADDR_W(AW)) u_subword_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
    .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic st, input int addr, input int sz, input logic sw,
                     input logic [63:0] wd, input string tag);
    int w, off, row;
    logic [63:0] r, v, d;
    logic err;
    exp_t it;
    w = 1 << sz; off = addr % 8; row = addr / 8;
    err = (off % w) != 0;
    r = ref_mem[row]; v = '0; d = '0;
    if (!err) begin
      if (!st) begin
        for (int i = 0; i < w; i++) v[8*i +: 8] = r[8*(off+i) +: 8];
        if (sw) for (int i = 0; i < w; i++) d[8*i +: 8] = v[8*(w-1-i) +: 8];
        else d = v;
      end else begin
        for (int i = 0; i < w; i++)
          r[8*(off+i) +: 8] = sw ? wd[8*(w-1-i) +: 8] : wd[8*i +: 8];
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = AW'(addr);
    req_size = 2'(sz); req_swap = sw; req_wdata = wd;
    it.d = st ? 64'd0 : d; it.e = err; it.tag = tag;
    q.push_back(it);
    #1;
    check({tag, " R1 row index"}, 64'(mem_addr), 64'(row));
    check({tag, " R3/R4 write enable"}, 64'(mem_we), 64'(st && !err));
    if (st && !err) begin
      check({tag, " R4 merged row"}, mem_wdata, r);
      ref_mem[row] = r;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) check("R9 response with no request", 64'd1, 64'd0);
        else begin
          exp_t it;
          it = q.pop_front();
          check({it.tag, " data"}, rsp_rdata, it.d);
          check({it.tag, " error flag"}, 64'(rsp_err), 64'(it.e));
        end
      end else if (rsp_err) check("R9 error without response", 64'd1, 64'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(rsp_valid), 64'd0);
    check("R10 reset error", 64'(rsp_err), 64'd0);
    check("R10 reset data", rsp_rdata, 64'd0);
    rst_n = 1'b1;
    req(0, 0, 3, 0, 0, "R2 R8 load empty row");
    req(1, 8, 3, 0, 64'h8877665544332211, "R8 full store");
    req(0, 8, 3, 0, 0, "R8 full load");
    req(0, 11, 0, 0, 0, "R2 byte lane 3");
    req(0, 15, 0, 0, 0, "R2 byte lane 7");
    req(0, 14, 1, 0, 0, "R2 half at 6");
    req(0, 12, 2, 0, 0, "R2 word at 4");
    req(0, 10, 1, 1, 0, "R6 swapped half");
    req(0, 8, 2, 1, 0, "R6 swapped word");
    req(0, 8, 3, 1, 0, "R6 swapped dword");
    req(1, 13, 0, 0, 64'hFFFF_FFFF_FFFF_FFAB, "R5 byte store junk upper");
    req(0, 8, 3, 0, 0, "R5 readback");
    req(1, 18, 1, 1, 64'h1234_5678_9ABC_BEEF, "R7 swapped half store");
    req(0, 16, 3, 0, 0, "R7 readback");
    req(1, 20, 2, 0, 64'hDEAD_0000_CAFE_F00D, "R4 word store upper");
    req(0, 16, 3, 0, 0, "R4 readback");
    idle(3);
    req(0, 9, 1, 0, 0, "R3 misaligned half load");
    req(1, 12, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 misaligned dword store");
    req(1, 14, 2, 1, 64'h0, "R3 misaligned word store");
    req(0, 8, 3, 0, 0, "R3 row unchanged after errors");
    req(1, 24, 3, 1, 64'h0102030405060708, "R7 R8 swapped full store");
    req(0, 24, 3, 0, 0, "R8 readback");
    req(0, 31, 0, 1, 0, "R6 swapped byte");
    idle(4);
    check("R9 all responses seen", 64'(q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule